// File: doc/BRIEF.md
# Satellite Control Bus Envelope Transmitter

This block generates the keying envelope for the 22 kHz carrier on a satellite dish control bus. A host presents up to `MAX_BYTES` message bytes, a length, a burst selection and a continuous-tone enable, then pulses `start`. The block holds the line quiet, sends each byte as pulse-width coded symbols followed by an odd-parity symbol, and holds the line quiet again. It can then send an optional burst, either a solid carrier burst or a data burst of all ones, and after a burst it waits a final quiet period. The output `env` is high wherever the external oscillator should be gated on.

All durations are counted in microseconds. A tick is derived from `CLK_HZ`, and the prescaler restarts at every phase boundary, so a phase of N microseconds lasts exactly N·(CLK_HZ/1e6) clock cycles. While no transfer runs, `env` follows the continuous-tone enable.

Top module: `dsq_env_tx`

## Requirements
- R1: After a synchronous active-high reset, `busy` is 0 and, with `tone_en` low, `env` is 0.
- R2: A one symbol is `env` high for `BIT_SHORT_US` and then low for `BIT_LONG_US`.
- R3: A zero symbol is `env` high for `BIT_LONG_US` and then low for `BIT_SHORT_US`.
- R4: Byte 0 is `msg_data[7:0]`, byte k is `msg_data[8k+7:8k]`, and bytes go in rising k order. Each byte is sent with bit 7 first and is followed by a parity symbol that makes the count of ones across the nine symbols odd.
- R5: `env` is low for `GAP_US` before the first byte and for `GAP_US` after the last symbol, and every transfer ends with `env` low.
- R6: `burst_sel` = 2'b01 adds a solid carrier of `BURST_US` after the trailing gap, then `TAIL_US` low before `busy` falls.
- R7: `burst_sel` = 2'b10 adds byte 0xFF with normal symbol and parity coding after the trailing gap, then `TAIL_US` low before `busy` falls.
- R8: `burst_sel` = 2'b00 or 2'b11 sends no burst and no tail wait, and `busy` falls right after the trailing gap.
- R9: With `msg_len` = 0, the transfer is the two gaps back to back, followed by the selected burst and its tail.
- R10: A `msg_len` above `MAX_BYTES` sends exactly `MAX_BYTES` bytes.
- R11: A `start` pulse while `busy` is high has no effect on the transfer in progress.
- R12: When idle, `env` equals `tone_en`. While busy, `tone_en` has no effect on `env`.
- R13: `busy` rises on the cycle after `start` is sampled while idle. Every phase lasts exactly its microsecond count times CLK_HZ/1e6 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a transfer when idle |
| msg_len | input | $clog2(MAX_BYTES+1)+1 | Requested byte count; values above MAX_BYTES are clamped |
| msg_data | input | 8*MAX_BYTES | Message bytes, byte 0 in the low octet |
| burst_sel | input | 2 | 00 none, 01 solid burst, 10 data burst, 11 none |
| tone_en | input | 1 | Continuous carrier request, honoured only when idle |
| env | output | 1 | Carrier gate, high means carrier on |
| busy | output | 1 | High while a transfer is in progress |

## Verification
The bench builds the block with CLK_HZ = 2 MHz, so one microsecond spans two cycles and the prescaler reset at phase boundaries is exercised. It also scales every duration down by 100 (5/10 µs symbols, 160 µs gaps, 125 µs burst, 200 µs tail), which keeps whole transfers with both burst kinds short enough to run many of them. MAX_BYTES is set to 4, so an oversize length of 9 reaches the clamp with a 32-bit data port. Expected runs of equal envelope level are merged across phase boundaries and compared with the measured run lengths in cycles.

// File: rtl/dsq_pkg.sv
package dsq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_LEAD  = 3'd1,
        ST_MARK  = 3'd2,
        ST_SPACE = 3'd3,
        ST_TRAIL = 3'd4,
        ST_TONE  = 3'd5,
        ST_HUSH  = 3'd6
    } dsq_state_e;

    typedef enum logic [1:0] {
        BSEL_NONE = 2'b00,
        BSEL_TONE = 2'b01,
        BSEL_DATA = 2'b10,
        BSEL_RSVD = 2'b11
    } dsq_burst_e;

    localparam logic [7:0] BURST_BYTE = 8'hFF;

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // parity symbol that makes the nine symbols carry an odd count of ones
    function automatic logic odd_fill(input logic [7:0] b);
        return ~^b;
    endfunction

endpackage

// File: rtl/dsq_phase_timer.sv
module dsq_phase_timer #(
    parameter int DIV  = 27,
    parameter int US_W = 15
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clear,
    input  logic [US_W-1:0] dur_us,
    output logic            expire
);
    logic            tick;
    logic [US_W-1:0] us_q;

    generate
        if (DIV <= 1) begin : g_direct
            assign tick = 1'b1;
        end else begin : g_prescale
            localparam int PRE_W = $clog2(DIV);
            logic [PRE_W-1:0] pre_q;

            always_ff @(posedge clk) begin
                if (rst || clear) begin
                    pre_q <= '0;
                end else if (pre_q == PRE_W'(DIV - 1)) begin
                    pre_q <= '0;
                end else begin
                    pre_q <= pre_q + 1'b1;
                end
            end

            assign tick = (pre_q == PRE_W'(DIV - 1));

            p_prescale_bound_r13: assert property (@(posedge clk) disable iff (rst)
                pre_q <= PRE_W'(DIV - 1));
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            us_q <= '0;
        end else if (tick) begin
            us_q <= us_q + 1'b1;
        end
    end

    assign expire = tick && (us_q == dur_us - 1'b1);

endmodule

// File: rtl/dsq_bit_source.sv
module dsq_bit_source #(
    parameter int MAX_BYTES = 6,
    parameter int LEN_W     = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   load_msg,
    input  logic                   load_burst,
    input  logic [8*MAX_BYTES-1:0] msg_data,
    input  logic [LEN_W-1:0]       msg_len,
    input  logic                   step,
    output logic                   cur_bit,
    output logic                   frame_end,
    output logic                   empty
);
    import dsq_pkg::*;

    localparam int IDX_W = $clog2(MAX_BYTES + 1);

    logic [8*MAX_BYTES-1:0] buf_q;
    logic [IDX_W-1:0]       nbytes_q;
    logic [IDX_W-1:0]       bidx_q;
    logic [3:0]             bitpos_q;
    logic [IDX_W-1:0]       len_eff;
    logic [7:0]             cur_byte;

    assign len_eff = (msg_len > LEN_W'(MAX_BYTES)) ? IDX_W'(MAX_BYTES) : msg_len[IDX_W-1:0];

    always_comb begin
        cur_byte = '0;
        for (int i = 0; i < MAX_BYTES; i++) begin
            if (bidx_q == IDX_W'(i)) cur_byte = buf_q[8*i +: 8];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            buf_q    <= '0;
            nbytes_q <= '0;
            bidx_q   <= '0;
            bitpos_q <= '0;
        end else if (load_msg) begin
            buf_q    <= msg_data;
            nbytes_q <= len_eff;
            bidx_q   <= '0;
            bitpos_q <= '0;
        end else if (load_burst) begin
            buf_q[7:0] <= BURST_BYTE;
            nbytes_q   <= IDX_W'(1);
            bidx_q     <= '0;
            bitpos_q   <= '0;
        end else if (step) begin
            if (bitpos_q == 4'd8) begin
                bitpos_q <= '0;
                bidx_q   <= bidx_q + 1'b1;
            end else begin
                bitpos_q <= bitpos_q + 1'b1;
            end
        end
    end

    assign cur_bit   = (bitpos_q == 4'd8) ? odd_fill(cur_byte) : cur_byte[3'd7 - bitpos_q[2:0]];
    assign frame_end = (bitpos_q == 4'd8) && (bidx_q == nbytes_q - 1'b1);
    assign empty     = (nbytes_q == '0);

    p_len_clamped_r10: assert property (@(posedge clk) disable iff (rst)
        nbytes_q <= IDX_W'(MAX_BYTES));

endmodule

// File: rtl/dsq_env_tx.sv
module dsq_env_tx #(
    parameter int CLK_HZ       = 27_000_000,
    parameter int MAX_BYTES    = 6,
    parameter int BIT_SHORT_US = 500,
    parameter int BIT_LONG_US  = 1000,
    parameter int GAP_US       = 16000,
    parameter int BURST_US     = 12500,
    parameter int TAIL_US      = 20000,
    localparam int LEN_W       = $clog2(MAX_BYTES + 1) + 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   start,
    input  logic [LEN_W-1:0]       msg_len,
    input  logic [8*MAX_BYTES-1:0] msg_data,
    input  logic [1:0]             burst_sel,
    input  logic                   tone_en,
    output logic                   env,
    output logic                   busy
);
    import dsq_pkg::*;

    localparam int DIV    = CLK_HZ / 1_000_000;
    localparam int MAX_US = max2(max2(max2(BIT_SHORT_US, BIT_LONG_US), max2(GAP_US, BURST_US)), TAIL_US);
    localparam int US_W   = $clog2(MAX_US + 1);

    dsq_state_e      state_q;
    dsq_burst_e      bsel_q;
    logic            in_burst_q;
    logic            accept;
    logic            expire;
    logic            tmr_clear;
    logic [US_W-1:0] dur_us;
    logic            cur_bit;
    logic            frame_end;
    logic            empty;
    logic            src_step;
    logic            src_burst;

    assign busy   = (state_q != ST_IDLE);
    assign accept = !busy && start;

    always_comb begin
        unique case (state_q)
            ST_LEAD, ST_TRAIL: dur_us = US_W'(GAP_US);
            ST_MARK:           dur_us = cur_bit ? US_W'(BIT_SHORT_US) : US_W'(BIT_LONG_US);
            ST_SPACE:          dur_us = cur_bit ? US_W'(BIT_LONG_US)  : US_W'(BIT_SHORT_US);
            ST_TONE:           dur_us = US_W'(BURST_US);
            ST_HUSH:           dur_us = US_W'(TAIL_US);
            default:           dur_us = US_W'(1);
        endcase
    end

    assign tmr_clear = accept || expire;
    assign src_step  = expire && (state_q == ST_SPACE);
    assign src_burst = expire && (state_q == ST_TRAIL) && (bsel_q == BSEL_DATA);

    dsq_phase_timer #(
        .DIV  (DIV),
        .US_W (US_W)
    ) u_timer (
        .clk    (clk),
        .rst    (rst),
        .clear  (tmr_clear),
        .dur_us (dur_us),
        .expire (expire)
    );

    dsq_bit_source #(
        .MAX_BYTES (MAX_BYTES),
        .LEN_W     (LEN_W)
    ) u_src (
        .clk        (clk),
        .rst        (rst),
        .load_msg   (accept),
        .load_burst (src_burst),
        .msg_data   (msg_data),
        .msg_len    (msg_len),
        .step       (src_step),
        .cur_bit    (cur_bit),
        .frame_end  (frame_end),
        .empty      (empty)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            bsel_q     <= BSEL_NONE;
            in_burst_q <= 1'b0;
        end else if (accept) begin
            state_q    <= ST_LEAD;
            bsel_q     <= dsq_burst_e'(burst_sel);
            in_burst_q <= 1'b0;
        end else if (expire) begin
            unique case (state_q)
                ST_LEAD:  state_q <= empty ? ST_TRAIL : ST_MARK;
                ST_MARK:  state_q <= ST_SPACE;
                ST_SPACE: begin
                    if (!frame_end)      state_q <= ST_MARK;
                    else if (in_burst_q) state_q <= ST_HUSH;
                    else                 state_q <= ST_TRAIL;
                end
                ST_TRAIL: begin
                    unique case (bsel_q)
                        BSEL_TONE: state_q <= ST_TONE;
                        BSEL_DATA: begin
                            state_q    <= ST_MARK;
                            in_burst_q <= 1'b1;
                        end
                        default:   state_q <= ST_IDLE;
                    endcase
                end
                ST_TONE:  state_q <= ST_HUSH;
                ST_HUSH:  state_q <= ST_IDLE;
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    assign env = busy ? ((state_q == ST_MARK) || (state_q == ST_TONE)) : tone_en;

    p_start_takes_r13: assert property (@(posedge clk) disable iff (rst)
        (!busy && start) |=> busy);

    p_end_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> !$past(env));

    p_hold_request_r11: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> $stable(bsel_q));

    p_burst_only_after_trail_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(in_burst_q) |-> (state_q == ST_MARK));

endmodule

// File: tb/dsq_env_tx_bench.sv
module dsq_env_tx_bench;

    localparam int CLK_PERIOD = 10;
    localparam int CLK_HZ     = 2_000_000;
    localparam int DIV        = CLK_HZ / 1_000_000;
    localparam int MAXB       = 4;
    localparam int T_SHORT    = 5;
    localparam int T_LONG     = 10;
    localparam int T_GAP      = 160;
    localparam int T_BURST    = 125;
    localparam int T_TAIL     = 200;
    localparam int LW         = $clog2(MAXB + 1) + 1;

    typedef struct {
        logic  lvl;
        int    cyc;
        string tag;
    } seg_t;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            start = 1'b0;
    logic [LW-1:0]   msg_len = '0;
    logic [8*MAXB-1:0] msg_data = '0;
    logic [1:0]      burst_sel = 2'b00;
    logic            tone_en = 1'b0;
    logic            env;
    logic            busy;

    int   n_tests = 0;
    int   n_fail  = 0;
    seg_t exp_q[$];

    logic run_on  = 1'b0;
    logic run_lvl = 1'b0;
    int   run_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dsq_env_tx #(
        .CLK_HZ       (CLK_HZ),
        .MAX_BYTES    (MAXB),
        .BIT_SHORT_US (T_SHORT),
        .BIT_LONG_US  (T_LONG),
        .GAP_US       (T_GAP),
        .BURST_US     (T_BURST),
        .TAIL_US      (T_TAIL)
    ) u_dsq_env_tx (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .msg_len   (msg_len),
        .msg_data  (msg_data),
        .burst_sel (burst_sel),
        .tone_en   (tone_en),
        .env       (env),
        .busy      (busy)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic push_seg(input logic lvl, input int us, input string tag);
        seg_t s;
        if (exp_q.size() > 0 && exp_q[exp_q.size()-1].lvl == lvl) begin
            s = exp_q.pop_back();
            s.cyc += us * DIV;
            exp_q.push_back(s);
        end else begin
            s.lvl = lvl;
            s.cyc = us * DIV;
            s.tag = tag;
            exp_q.push_back(s);
        end
    endtask

    task automatic push_byte(input logic [7:0] b, input string tag);
        int ones = 0;
        for (int i = 7; i >= 0; i--) begin
            ones += int'(b[i]);
            // R2: one = short high then long low; R3: zero = long high then short low
            push_seg(1'b1, b[i] ? T_SHORT : T_LONG, tag);
            push_seg(1'b0, b[i] ? T_LONG : T_SHORT, tag);
        end
        // R4: parity symbol makes the nine symbols carry an odd count of ones
        if (ones % 2 == 0) begin
            push_seg(1'b1, T_SHORT, tag);
            push_seg(1'b0, T_LONG, tag);
        end else begin
            push_seg(1'b1, T_LONG, tag);
            push_seg(1'b0, T_SHORT, tag);
        end
    endtask

    // flush a finished run of constant envelope level into the scoreboard
    task automatic flush_run();
        seg_t s;
        if (exp_q.size() == 0) begin
            check(1'b0, "R5 unexpected envelope run", run_cnt, 0);
        end else begin
            s = exp_q.pop_front();
            check(run_lvl == s.lvl, {s.tag, " level"}, int'(run_lvl), int'(s.lvl));
            check(run_cnt == s.cyc, {s.tag, " run length"}, run_cnt, s.cyc);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && busy) begin
            if (!run_on) begin
                run_on  = 1'b1;
                run_lvl = env;
                run_cnt = 1;
            end else if (env == run_lvl) begin
                run_cnt++;
            end else begin
                flush_run();
                run_lvl = env;
                run_cnt = 1;
            end
        end else if (run_on) begin
            flush_run();
            run_on = 1'b0;
        end
    end

    task automatic send(input logic [8*MAXB-1:0] data, input int len, input logic [1:0] bsel,
                        input bit glitch, input logic tone_during, input string tag);
        int eff;
        eff = (len > MAXB) ? MAXB : len;
        push_seg(1'b0, T_GAP, {tag, " R5 lead gap"});
        for (int k = 0; k < eff; k++) push_byte(data[8*k +: 8], {tag, " R4 byte"});
        push_seg(1'b0, T_GAP, {tag, " R5 trail gap"});
        if (bsel == 2'b01) begin
            push_seg(1'b1, T_BURST, {tag, " R6 solid burst"});
            push_seg(1'b0, T_TAIL, {tag, " R6 tail"});
        end else if (bsel == 2'b10) begin
            push_byte(8'hFF, {tag, " R7 data burst"});
            push_seg(1'b0, T_TAIL, {tag, " R7 tail"});
        end
        @(negedge clk);
        check(busy == 1'b0, {tag, " R13 idle before start"}, int'(busy), 0);
        msg_data  = data;
        msg_len   = LW'(len);
        burst_sel = bsel;
        start     = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, {tag, " R13 busy one cycle after start"}, int'(busy), 1);
        tone_en = tone_during;
        if (glitch) begin
            repeat (50) @(negedge clk);
            msg_data  = ~data;
            msg_len   = LW'(1);
            burst_sel = 2'b10;
            start     = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (busy) @(negedge clk);
        tone_en = 1'b0;
        repeat (2) @(negedge clk);
        check(exp_q.size() == 0, {tag, " R8 all expected runs seen"}, exp_q.size(), 0);
        exp_q.delete();
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check(busy == 1'b0, "R1 busy after reset", int'(busy), 0);
        check(env == 1'b0, "R1 env after reset", int'(env), 0);

        // R12: idle envelope follows tone_en
        tone_en = 1'b1;
        @(negedge clk);
        check(env == 1'b1, "R12 idle tone on", int'(env), 1);
        tone_en = 1'b0;
        @(negedge clk);
        check(env == 1'b0, "R12 idle tone off", int'(env), 0);

        // R2 R3 R4 R5 R8: three bytes, no burst
        send({8'h00, 8'h38, 8'h10, 8'hE0}, 3, 2'b00, 1'b0, 1'b0, "msgA");
        // R9 R6: empty message with solid burst
        send('0, 0, 2'b01, 1'b0, 1'b0, "msgB");
        // R7: two bytes then data burst
        send({16'h0000, 8'h00, 8'hA5}, 2, 2'b10, 1'b0, 1'b0, "msgC");
        // R10 R8: oversize length clamped, reserved burst code sends nothing
        send({8'h81, 8'h7E, 8'hC3, 8'h3C}, 9, 2'b11, 1'b0, 1'b0, "msgD");
        // R11 R12: start pulse mid-transfer ignored, tone_en held high while busy
        send({24'h0, 8'h5A}, 1, 2'b01, 1'b1, 1'b1, "msgE");
        // R9 R7: empty message with data burst
        send('0, 0, 2'b10, 1'b0, 1'b0, "msgF");

        @(negedge clk);
        check(busy == 1'b0, "R12 idle after runs", int'(busy), 0);
        check(env == 1'b0, "R12 idle env low", int'(env), 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule